// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block sends characters as asynchronous serial frames. A single holding register sits in front of the frame shifter, so software can write the next character while the current one is still leaving the TX pin. The block moves the held character into the shifter as soon as the shifter is free. If a frame is ending at that moment, the new frame follows on the next bit period with no gap. A flag reports that the holding register is empty, and an interrupt follows that flag through an enable bit. A second flag reports that the line has gone quiet after the last frame.

Bit timing comes from an internal divider. The divider restarts at the start of every frame, so each bit lasts exactly `cfg_div + 1` clock cycles. A character has 8 or 9 data bits and is followed by 1 or 2 stop bits. When transmission is switched on, the block first sends one frame-length stretch of high level before any data. While a data bit is on the line, a clock is driven on `ck`.

Top module: `usart_tx_dbuf`

## Requirements
- R1: A data frame is one low start bit, then the character least significant bit first, then the stop bits at high level. `tx` is high whenever no frame is in progress.
- R2: `cfg_nine` = 0 sends `wr_data[7:0]` (8 data bits). `cfg_nine` = 1 sends `wr_data[8:0]` (9 data bits). The setting is taken when the frame is loaded.
- R3: `cfg_two_stop` = 0 gives 1 stop bit and `cfg_two_stop` = 1 gives 2 stop bits, taken when the frame is loaded.
- R4: Every bit of every frame lasts exactly `cfg_div + 1` clock cycles. `cfg_div` must be at least 1.
- R5: A `wr_en` pulse stores `wr_data` in the holding register. From the next cycle, `buf_empty` is 0 and `tx_done` is 0.
- R6: When the held character moves into the shifter, `buf_empty` returns to 1. A character written during a frame stays held until that frame ends, and its frame then starts on the next bit period with no gap.
- R7: `irq` is 1 exactly when `buf_empty` is 1 and `bufe_ie` is 1.
- R8: After `tx_en` goes from 0 to 1, the block sends one idle period before any data. The idle period is as long as a frame at the current settings and is all high, with no start bit.
- R9: `tx_done` becomes 1 when the final bit of a frame ends and nothing is waiting to follow it. A `tc_clr` pulse or a write clears it, and a clear wins over a set in the same cycle.
- R10: `ck` is high during the second half of each data bit, meaning the cycles whose bit-cycle index is at least (`cfg_div`+1)/2. It is low during start bits, stop bits, idle periods and gaps.
- R11: With `tx_en` at 0, nothing is sent and `tx` stays high. Dropping `tx_en` during a frame abandons that frame one cycle later. The holding register and its flag keep their contents across the abort.
- R12: After reset: `tx` = 1, `ck` = 0, `buf_empty` = 1, `tx_done` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_div | input | DIV_W | Clock cycles per bit minus one |
| cfg_nine | input | 1 | 1: 9 data bits, 0: 8 data bits |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| tx_en | input | 1 | Transmit enable |
| bufe_ie | input | 1 | Interrupt enable for buffer empty |
| wr_en | input | 1 | One-cycle write strobe for the holding register |
| wr_data | input | 9 | Character to send |
| tc_clr | input | 1 | One-cycle clear of `tx_done` |
| tx | output | 1 | Serial line |
| ck | output | 1 | Bit clock during data bits |
| buf_empty | output | 1 | Holding register empty |
| tx_done | output | 1 | Transmission complete |
| irq | output | 1 | Buffer-empty interrupt |

## Verification
The hardest case to reach is a write that lands while a frame is in flight, followed by a hand-over on the exact cycle the last stop bit ends. A second hard case is an abort in mid-frame with a character still held. The stimulus reaches the first case by waiting for `buf_empty` to rise right after a load, then writing at once, so the next character is held for nearly a full frame. It reaches the second by dropping `tx_en` part-way through a frame, writing while the block is disabled, and enabling again. That checks that the idle period comes before the held character.

// File: rtl/utx_pkg.sv
// Package: shared constants and frame-length helper for the buffered
// serial transmitter. Assumes at most 9 data bits and 2 stop bits.
package utx_pkg;
    localparam int MAX_DATA = 9;
    localparam int MAX_STOP = 2;
    localparam int FRAME_W  = 1 + MAX_DATA + MAX_STOP;
    localparam int POS_W    = $clog2(FRAME_W + 1);

    // Number of bit periods in one frame for the given settings.
    function automatic logic [POS_W-1:0] frame_len(input logic nine, input logic two);
        logic [POS_W-1:0] n;
        n = POS_W'(1 + 8 + 1);
        if (nine) n = n + POS_W'(1);
        if (two)  n = n + POS_W'(1);
        return n;
    endfunction
endpackage

// File: rtl/utx_baud.sv
// Module: bit-period counter. Counts clock cycles while a frame is on the
// line and pulses 'tick' on the last cycle of each bit. A restart puts the
// count back to zero, so every frame starts on a clean bit boundary.
// Assumes cfg_div stays constant while a frame is in flight.
module utx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             run,
    input  logic             restart,
    output logic             tick,
    output logic             second_half
);
    localparam int HW = DIV_W + 1;

    logic [DIV_W-1:0] bcnt;
    logic [HW-1:0]    half;

    assign tick        = run && (bcnt == cfg_div);
    assign half        = ({1'b0, cfg_div} + HW'(1)) >> 1;
    assign second_half = ({1'b0, bcnt} >= half);

    // Advance the in-bit cycle count, wrapping at the divider value.
    always_ff @(posedge clk) begin
        if (!rst_n)              bcnt <= '0;
        else if (!run || restart) bcnt <= '0;
        else if (tick)           bcnt <= '0;
        else                     bcnt <= bcnt + DIV_W'(1);
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart) |-> (bcnt <= cfg_div));
endmodule

// File: rtl/utx_hold.sv
// Module: holding register and the two status flags. A write fills the
// holding register. A load by the shifter empties it. tx_done is set by
// the shifter's finish strobe and cleared by a write or an explicit clear.
// Assumes load is only asserted while the register is full.
module utx_hold #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    input  logic              tc_clr,
    input  logic              done_set,
    output logic [DATA_W-1:0] hold_q,
    output logic              buf_empty,
    output logic              tx_done
);
    // Capture written data; a write has priority over emptying.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            buf_empty <= 1'b1;
        end else if (wr_en) begin
            hold_q    <= wr_data;
            buf_empty <= 1'b0;
        end else if (load) begin
            buf_empty <= 1'b1;
        end
    end

    // Transmission-complete flag; a clear wins over a set.
    always_ff @(posedge clk) begin
        if (!rst_n)                tx_done <= 1'b1;
        else if (wr_en || tc_clr)  tx_done <= 1'b0;
        else if (done_set)         tx_done <= 1'b1;
    end

    // R5
    wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!buf_empty && !tx_done));
    // R6
    empty_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty) |-> $past(load));
endmodule

// File: rtl/utx_shifter.sv
// Module: frame shifter and sequencing. It sends the idle period after
// enable, loads held characters (chaining onto the last tick of a frame),
// shifts bits out LSB first, and marks data-bit windows for the clock pin.
// Assumes tick comes from a counter restarted on every load.
module utx_shifter
    import utx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              cfg_nine,
    input  logic              cfg_two_stop,
    input  logic              tick,
    input  logic              second_half,
    input  logic [DATA_W-1:0] hold_q,
    input  logic              buf_empty,
    output logic              busy,
    output logic              load_any,
    output logic              load_data,
    output logic              done_set,
    output logic              tx,
    output logic              ck
);
    logic [FRAME_W-1:0] sr;
    logic [POS_W-1:0]   pos, len_q;
    logic               idle_fr, nine_q, en_q, pend_idle;
    logic               last, can_load, load_idle, data_bit;
    logic [FRAME_W-1:0] frame_img;

    assign last      = tx_en && busy && tick && (pos == len_q - POS_W'(1));
    assign can_load  = tx_en && en_q && (!busy || last);
    assign load_idle = can_load && pend_idle;
    assign load_data = can_load && !pend_idle && !buf_empty;
    assign load_any  = load_idle || load_data;
    assign done_set  = last && !load_any;

    // Build the frame image: start bit at bit 0, then data, then high fill.
    always_comb begin
        frame_img            = '1;
        frame_img[0]         = 1'b0;
        frame_img[8:1]       = hold_q[7:0];
        frame_img[9]         = cfg_nine ? hold_q[8] : 1'b1;
    end

    // Sequence frames: idle request, load, shift on tick, abort on disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '1; busy <= 1'b0; pos <= '0; len_q <= '0;
            idle_fr <= 1'b0; nine_q <= 1'b0; en_q <= 1'b0; pend_idle <= 1'b0;
        end else begin
            en_q <= tx_en;
            if (!tx_en) begin
                sr <= '1; busy <= 1'b0; pos <= '0; pend_idle <= 1'b0;
            end else begin
                if (!en_q)          pend_idle <= 1'b1;
                else if (load_idle) pend_idle <= 1'b0;
                if (load_any) begin
                    busy    <= 1'b1;
                    pos     <= '0;
                    idle_fr <= load_idle;
                    nine_q  <= cfg_nine;
                    len_q   <= frame_len(cfg_nine, cfg_two_stop);
                    sr      <= load_idle ? '1 : frame_img;
                end else if (busy && tick) begin
                    if (last) busy <= 1'b0;
                    pos <= pos + POS_W'(1);
                    sr  <= {1'b1, sr[FRAME_W-1:1]};
                end
            end
        end
    end

    assign data_bit = busy && !idle_fr && (pos != '0) &&
                      (pos <= (nine_q ? POS_W'(9) : POS_W'(8)));
    assign ck = data_bit && second_half;
    assign tx = sr[0];

    // R1
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_data |=> !tx);
    // R8
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_idle |=> tx);
    // R6
    load_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_data |-> !buf_empty);
endmodule

// File: rtl/usart_tx_dbuf.sv
// Module: top of the buffered serial transmitter. It wires the holding
// register, the frame shifter and the bit-period counter together and
// forms the interrupt. Assumes wr_en and tc_clr are one-cycle strobes.
module usart_tx_dbuf
    import utx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_nine,
    input  logic             cfg_two_stop,
    input  logic             tx_en,
    input  logic             bufe_ie,
    input  logic             wr_en,
    input  logic [8:0]       wr_data,
    input  logic             tc_clr,
    output logic             tx,
    output logic             ck,
    output logic             buf_empty,
    output logic             tx_done,
    output logic             irq
);
    logic [MAX_DATA-1:0] hold_q;
    logic busy, load_any, load_data, done_set, tick, second_half;

    utx_hold #(.DATA_W(MAX_DATA)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .load(load_data), .tc_clr(tc_clr), .done_set(done_set),
        .hold_q(hold_q), .buf_empty(buf_empty), .tx_done(tx_done));

    utx_shifter #(.DATA_W(MAX_DATA)) u_shift (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cfg_nine(cfg_nine),
        .cfg_two_stop(cfg_two_stop), .tick(tick), .second_half(second_half),
        .hold_q(hold_q), .buf_empty(buf_empty), .busy(busy),
        .load_any(load_any), .load_data(load_data), .done_set(done_set),
        .tx(tx), .ck(ck));

    utx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .run(busy),
        .restart(load_any), .tick(tick), .second_half(second_half));

    assign irq = buf_empty && bufe_ie;

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> tx);
    // R10
    ck_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ck |-> (busy && !tx_done));
endmodule

// File: tb/tb_usart_tx_dbuf.sv
module tb_usart_tx_dbuf;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] cfg_div = 16'd3;
    logic cfg_nine = 1'b0, cfg_two_stop = 1'b0, tx_en = 1'b0, bufe_ie = 1'b1;
    logic wr_en = 1'b0, tc_clr = 1'b0;
    logic [8:0] wr_data = '0;
    logic tx, ck, buf_empty, tx_done, irq;

    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    usart_tx_dbuf dut (.*);

    // Reference model: a queue of pending line bits (bit0 = level, bit1 = data bit).
    int  q[$];
    int  timer = 0;
    bit  m_empty = 1, m_tc = 1, m_pend = 0, m_enq = 0;
    bit [8:0] m_hold = '0;

    always @(posedge clk) begin
        bit busy, tick, last, canl, di, dd;
        int nb, ns;
        if (!rst_n) begin
            q.delete(); timer = 0; m_empty = 1; m_tc = 1; m_pend = 0; m_enq = 0; m_hold = '0;
        end else begin
            busy = (q.size() > 0);
            tick = tx_en && busy && (timer == int'(cfg_div));
            last = tick && (q.size() == 1);
            canl = tx_en && m_enq && (!busy || last);
            di   = canl && m_pend;
            dd   = canl && !m_pend && !m_empty;
            nb   = cfg_nine ? 9 : 8;
            ns   = cfg_two_stop ? 2 : 1;
            if (!tx_en) begin
                q.delete(); timer = 0; m_pend = 0;
            end else begin
                if (!m_enq) m_pend = 1; else if (di) m_pend = 0;
                if (tick) begin void'(q.pop_front()); timer = 0; end
                else if (busy) timer++;
                if (di) begin
                    for (int i = 0; i < 1 + nb + ns; i++) q.push_back(1);
                    timer = 0;
                end
                if (dd) begin
                    q.push_back(0);
                    for (int i = 0; i < nb; i++) q.push_back(2 | int'(m_hold[i]));
                    for (int i = 0; i < ns; i++) q.push_back(1);
                    timer = 0;
                end
            end
            if (wr_en || tc_clr) m_tc = 0; else if (last && !di && !dd) m_tc = 1;
            if (wr_en) begin m_hold = wr_data; m_empty = 0; end else if (dd) m_empty = 1;
            m_enq = tx_en;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int etx, eck;
            etx = (q.size() > 0) ? (q[0] & 1) : 1;
            eck = (q.size() > 0) && ((q[0] & 2) != 0) && (timer >= (int'(cfg_div) + 1) / 2);
            chk("R1", "tx", int'(tx), etx);
            chk("R10", "ck", int'(ck), eck);
            chk("R6", "buf_empty", int'(buf_empty), int'(m_empty));
            chk("R9", "tx_done", int'(tx_done), int'(m_tc));
            chk("R7", "irq", int'(irq), int'(m_empty && bufe_ie));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(logic [8:0] d);
        wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_empty();
        while (!buf_empty) @(negedge clk);
    endtask

    task automatic wait_done();
        while (!tx_done) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(150000 * 20);
        errors++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int cnt;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R12 reset state
        chk("R12", "tx", int'(tx), 1);
        chk("R12", "ck", int'(ck), 0);
        chk("R12", "buf_empty", int'(buf_empty), 1);
        chk("R12", "tx_done", int'(tx_done), 1);

        // R11 / R5: a write while disabled is held, nothing is sent
        write(9'h0A5);
        chk("R5", "buf_empty after write", int'(buf_empty), 0);
        chk("R5", "tx_done after write", int'(tx_done), 0);
        cyc(30);
        chk("R11", "tx while disabled", int'(tx), 1);

        // R8: enabling sends an idle period before the held character
        tx_en = 1'b1;
        cnt = 0;
        while (tx) begin @(negedge clk); cnt++; end
        chk("R8", "idle period >= frame length", int'(cnt >= 40), 1);

        // R6: write during a frame, hand-over with no gap; R2 8-bit, R3 1 stop
        wait_empty();
        write(9'h13C);
        wait_empty();
        write(9'h00F);
        wait_done();
        chk("R9", "tx_done after last frame", int'(tx_done), 1);
        chk("R1", "line idle high", int'(tx), 1);

        // R9: explicit clear
        tc_clr = 1'b1; cyc(1); tc_clr = 1'b0;
        chk("R9", "tx_done cleared", int'(tx_done), 0);

        // R2 / R3 / R4: 9 data bits, 2 stop bits, slower bit period
        cfg_div = 16'd4; cfg_nine = 1'b1; cfg_two_stop = 1'b1;
        write(9'h155);
        wait_empty();
        write(9'h0AA);
        wait_done();

        // R7: interrupt masked while empty
        bufe_ie = 1'b0; cyc(2);
        chk("R7", "irq masked", int'(irq), 0);
        bufe_ie = 1'b1; cyc(1);
        chk("R7", "irq enabled", int'(irq), 1);

        // R11: abort mid-frame, hold a character while disabled, re-enable
        cfg_div = 16'd3; cfg_nine = 1'b0; cfg_two_stop = 1'b0;
        write(9'h066);
        cyc(20);
        tx_en = 1'b0;
        cyc(2);
        chk("R11", "tx after abort", int'(tx), 1);
        write(9'h081);
        cyc(10);
        chk("R11", "held across disable", int'(buf_empty), 0);
        tx_en = 1'b1;
        wait_done();

        // R4 / R10: shortest bit period with 2 stop bits
        cfg_div = 16'd1; cfg_two_stop = 1'b1;
        write(9'h1E7);
        wait_empty();
        write(9'h018);
        wait_done();
        cyc(5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule